// File: doc/BRIEF.md
# Dual-Mode Proportional-Integral Loop Filter

This block is the loop filter of a carrier-recovery loop. It turns each signed phase-error sample into a control word for a numerically controlled oscillator. Two first-order proportional-plus-integral filters run side by side on every valid sample. One is a wide filter with large gains for pulling the loop in. The other is a narrow filter with small gains for holding lock once it is reached.

A signed lock metric comes in with each error sample. When the metric is at or above a threshold set at build time, the narrow filter drives the output and a status bit reads 1. Below the threshold, the wide filter drives the output and the status bit reads 0. Both integrators keep running all the time. A change of mode therefore switches to an integrator that is already current, not to one that was frozen earlier.

Gains are unsigned fixed-point constants with `FRAC_W` fraction bits. The defaults are Q8.8 values: 9763/288 (Kp/Ki) for the wide filter and 1220/36 for the narrow one. These stand for about 38.14/1.12 and 4.77/0.14. The default threshold is 9950.

Top module: `dual_mode_loop_filter`

## Requirements
- R1: `validOut` is 1 in the clock cycle after each cycle with `validIn` high, and 0 after each cycle with `validIn` low.
- R2: In wide mode, the accepted sample e gives `ctrlOut = sat_OUT((9763*e + Ia) >>> 8)`, where Ia is the wide integrator after it has added `288*e`. The shift is arithmetic (floor).
- R3: In narrow mode, the accepted sample gives `ctrlOut = sat_OUT((1220*e + It) >>> 8)`, where It is the narrow integrator after it has added `36*e`.
- R4: Take `metricIn` as a signed number. If it is below 9950, the sample uses the wide result and `trackMode` becomes 0. Otherwise the sample uses the narrow result and `trackMode` becomes 1.
- R5: Both integrators take in every valid sample, whichever mode is selected.
- R6: Each integrator saturates to the signed `ACC_W`-bit range (default 26 bits: -33554432 to 33554431) and never wraps.
- R7: `ctrlOut` saturates to the signed `OUT_W`-bit range (default 21 bits: -1048576 to 1048575).
- R8: A cycle with `validIn` low leaves `ctrlOut`, `trackMode` and both integrators unchanged.
- R9: While reset is asserted, both integrators are 0 and `ctrlOut`, `trackMode` and `validOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Strobe marking a new error sample |
| errIn | input | ERR_W (16) | Signed loop error sample |
| metricIn | input | METRIC_W (16) | Signed lock metric |
| validOut | output | 1 | Control word updated this cycle |
| ctrlOut | output | OUT_W (21) | Signed filtered control word |
| trackMode | output | 1 | 1 = narrow (tracking) filter selected |

## Verification
Small directed errors with the metric held at 9949 and then at 9950 show whether the threshold comparison picks the right gain set and status. A run of full-scale positive errors followed by zero errors brings out the wide integrator's saturated value on its own, separate from output clipping. A full-scale negative error shows output clipping. Long random runs keep switching mode with gaps between samples. These show whether the deselected integrator keeps accumulating and whether idle cycles disturb any state.

// File: rtl/lf_pkg.sv
package lf_pkg;

  // Default Q8.8 gains (value * 256, rounded)
  localparam int unsigned ACQ_KP_Q = 9763;
  localparam int unsigned ACQ_KI_Q = 288;
  localparam int unsigned TRK_KP_Q = 1220;
  localparam int unsigned TRK_KI_Q = 36;
  localparam int          LOCK_THRESH_DEF = 9950;

  // Control-to-datapath strobes
  typedef struct packed {
    logic update;    // accept the current error sample
    logic selTrack;  // pick the narrow filter for this sample
  } lf_strobe_t;

endpackage

// File: rtl/lf_ctrl.sv
module lf_ctrl #(
  parameter int METRIC_W    = 16,
  parameter int LOCK_THRESH = lf_pkg::LOCK_THRESH_DEF
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       validIn,
  input  logic signed [METRIC_W-1:0] metricIn,
  output lf_pkg::lf_strobe_t         strb,
  output logic                       trackMode
);
  localparam logic signed [METRIC_W-1:0] THRESH_S = METRIC_W'(LOCK_THRESH);

  logic aboveThresh;
  assign aboveThresh = (metricIn >= THRESH_S);

  always_comb begin
    strb.update   = validIn;
    strb.selTrack = aboveThresh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        trackMode <= 1'b0;
    else if (validIn) trackMode <= aboveThresh;
  end
endmodule

// File: rtl/lf_pi_branch.sv
module lf_pi_branch #(
  parameter int          ERR_W  = 16,
  parameter int          GAIN_W = 16,
  parameter int          FRAC_W = 8,
  parameter int          ACC_W  = 26,
  parameter int          OUT_W  = 21,
  parameter int unsigned KP     = 1,
  parameter int unsigned KI     = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    update,
  input  logic signed [ERR_W-1:0] errIn,
  output logic signed [OUT_W-1:0] filtOut
);
  localparam int PROD_W = ERR_W + GAIN_W + 1;
  localparam int SUM_W  = ((PROD_W > ACC_W) ? PROD_W : ACC_W) + 2;

  localparam logic signed [SUM_W-1:0] ACC_MAX = SUM_W'((64'sd1 <<< (ACC_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] ACC_MIN = SUM_W'(-(64'sd1 <<< (ACC_W - 1)));
  localparam logic signed [SUM_W-1:0] OUT_MAX = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] OUT_MIN = SUM_W'(-(64'sd1 <<< (OUT_W - 1)));
  localparam logic signed [PROD_W-1:0] KP_S = PROD_W'(KP);
  localparam logic signed [PROD_W-1:0] KI_S = PROD_W'(KI);

  logic signed [ACC_W-1:0]  integQ;
  logic signed [ACC_W-1:0]  integNext;
  logic signed [PROD_W-1:0] errExt;
  logic signed [PROD_W-1:0] prodP;
  logic signed [PROD_W-1:0] prodI;
  logic signed [SUM_W-1:0]  integSum;
  logic signed [SUM_W-1:0]  total;
  logic signed [SUM_W-1:0]  scaled;

  assign errExt = PROD_W'(errIn);
  assign prodP  = errExt * KP_S;
  assign prodI  = errExt * KI_S;

  // Integrator: add, then clamp to the accumulator range
  assign integSum = SUM_W'(integQ) + SUM_W'(prodI);
  always_comb begin
    if (integSum > ACC_MAX)      integNext = ACC_MAX[ACC_W-1:0];
    else if (integSum < ACC_MIN) integNext = ACC_MIN[ACC_W-1:0];
    else                         integNext = integSum[ACC_W-1:0];
  end

  // Proportional path plus updated integrator, rescaled and clamped
  assign total  = SUM_W'(prodP) + SUM_W'(integNext);
  assign scaled = total >>> FRAC_W;
  always_comb begin
    if (scaled > OUT_MAX)      filtOut = OUT_MAX[OUT_W-1:0];
    else if (scaled < OUT_MIN) filtOut = OUT_MIN[OUT_W-1:0];
    else                       filtOut = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       integQ <= '0;
    else if (update) integQ <= integNext;
  end
endmodule

// File: rtl/lf_datapath.sv
module lf_datapath #(
  parameter int          ERR_W  = 16,
  parameter int          GAIN_W = 16,
  parameter int          FRAC_W = 8,
  parameter int          ACC_W  = 26,
  parameter int          OUT_W  = 21,
  parameter int unsigned ACQ_KP = lf_pkg::ACQ_KP_Q,
  parameter int unsigned ACQ_KI = lf_pkg::ACQ_KI_Q,
  parameter int unsigned TRK_KP = lf_pkg::TRK_KP_Q,
  parameter int unsigned TRK_KI = lf_pkg::TRK_KI_Q
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  lf_pkg::lf_strobe_t      strb,
  input  logic signed [ERR_W-1:0] errIn,
  output logic                    validOut,
  output logic signed [OUT_W-1:0] ctrlOut
);
  localparam int N_BRANCH = 2;  // index 0 = wide, 1 = narrow

  logic signed [OUT_W-1:0] branchOut [N_BRANCH];

  for (genvar g = 0; g < N_BRANCH; g++) begin : g_branch
    lf_pi_branch #(
      .ERR_W (ERR_W),
      .GAIN_W(GAIN_W),
      .FRAC_W(FRAC_W),
      .ACC_W (ACC_W),
      .OUT_W (OUT_W),
      .KP    ((g == 0) ? ACQ_KP : TRK_KP),
      .KI    ((g == 0) ? ACQ_KI : TRK_KI)
    ) branch_i (
      .clk    (clk),
      .rstN   (rstN),
      .update (strb.update),
      .errIn  (errIn),
      .filtOut(branchOut[g])
    );
  end

  logic signed [OUT_W-1:0] selOut;
  assign selOut = strb.selTrack ? branchOut[1] : branchOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut <= 1'b0;
      ctrlOut  <= '0;
    end else begin
      validOut <= strb.update;
      if (strb.update) ctrlOut <= selOut;
    end
  end
endmodule

// File: rtl/dual_mode_loop_filter.sv
module dual_mode_loop_filter #(
  parameter int          ERR_W       = 16,
  parameter int          METRIC_W    = 16,
  parameter int          GAIN_W      = 16,
  parameter int          FRAC_W      = 8,
  parameter int          ACC_W       = 26,
  parameter int          OUT_W       = 21,
  parameter int          LOCK_THRESH = lf_pkg::LOCK_THRESH_DEF,
  parameter int unsigned ACQ_KP      = lf_pkg::ACQ_KP_Q,
  parameter int unsigned ACQ_KI      = lf_pkg::ACQ_KI_Q,
  parameter int unsigned TRK_KP      = lf_pkg::TRK_KP_Q,
  parameter int unsigned TRK_KI      = lf_pkg::TRK_KI_Q
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       validIn,
  input  logic signed [ERR_W-1:0]    errIn,
  input  logic signed [METRIC_W-1:0] metricIn,
  output logic                       validOut,
  output logic signed [OUT_W-1:0]    ctrlOut,
  output logic                       trackMode
);
  lf_pkg::lf_strobe_t strb;

  lf_ctrl #(
    .METRIC_W   (METRIC_W),
    .LOCK_THRESH(LOCK_THRESH)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .metricIn (metricIn),
    .strb     (strb),
    .trackMode(trackMode)
  );

  lf_datapath #(
    .ERR_W (ERR_W),
    .GAIN_W(GAIN_W),
    .FRAC_W(FRAC_W),
    .ACC_W (ACC_W),
    .OUT_W (OUT_W),
    .ACQ_KP(ACQ_KP),
    .ACQ_KI(ACQ_KI),
    .TRK_KP(TRK_KP),
    .TRK_KI(TRK_KI)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .errIn   (errIn),
    .validOut(validOut),
    .ctrlOut (ctrlOut)
  );
endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
  parameter int METRIC_W    = 16,
  parameter int OUT_W       = 21,
  parameter int LOCK_THRESH = 9950
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       validIn,
  input logic signed [METRIC_W-1:0] metricIn,
  input logic                       validOut,
  input logic signed [OUT_W-1:0]    ctrlOut,
  input logic                       trackMode
);
  localparam logic signed [METRIC_W-1:0] THR = METRIC_W'(LOCK_THRESH);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);

  // R4
  track_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && (metricIn >= THR)) |=> trackMode);

  // R4
  acq_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && (metricIn < THR)) |=> !trackMode);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(ctrlOut) && $stable(trackMode)));
endmodule

bind dual_mode_loop_filter lf_checker #(
  .METRIC_W   (METRIC_W),
  .OUT_W      (OUT_W),
  .LOCK_THRESH(LOCK_THRESH)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .validIn  (validIn),
  .metricIn (metricIn),
  .validOut (validOut),
  .ctrlOut  (ctrlOut),
  .trackMode(trackMode)
);

// File: tb/dual_mode_loop_filter_tb_top.sv
module dual_mode_loop_filter_tb_top;
  localparam int     ERR_W = 16, METRIC_W = 16, ACC_W = 26, OUT_W = 21, FRAC_W = 8;
  localparam longint THR = 9950;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0;
  logic signed [ERR_W-1:0]    errIn = '0;
  logic signed [METRIC_W-1:0] metricIn = '0;
  logic                       validOut;
  logic signed [OUT_W-1:0]    ctrlOut;
  logic                       trackMode;

  int errors = 0;
  int checks = 0;

  // Reference state
  longint mIntA = 0, mIntT = 0, mOut = 0;
  bit     mTrack = 1'b0;

  always #4 clk = ~clk;

  dual_mode_loop_filter dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .errIn(errIn),
    .metricIn(metricIn), .validOut(validOut), .ctrlOut(ctrlOut),
    .trackMode(trackMode)
  );

  function automatic longint satW(longint x, int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    longint lo = -(longint'(1) <<< (w - 1));
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  function automatic longint filt(longint kp, longint integ, longint e);
    return satW((kp * e + integ) >>> FRAC_W, OUT_W);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; validIn = 1'b0;
    @(negedge clk);
    mIntA = 0; mIntT = 0; mOut = 0; mTrack = 1'b0;
    // R9 reset state at the ports
    check(ctrlOut == 0, "R9 ctrlOut", ctrlOut, 0);
    check(trackMode == 0 && validOut == 0, "R9 flags", {trackMode, validOut}, 0);
    rstN = 1'b1;
  endtask

  task automatic step(bit v, longint e, longint m);
    string req;
    @(negedge clk);
    validIn = v; errIn = ERR_W'(e); metricIn = METRIC_W'(m);
    if (v) begin
      mIntA  = satW(mIntA + 288 * e, ACC_W);   // R5 R6
      mIntT  = satW(mIntT + 36 * e, ACC_W);
      mTrack = (m >= THR);                      // R4
      mOut   = mTrack ? filt(1220, mIntT, e) : filt(9763, mIntA, e);
    end
    @(posedge clk);
    #2;
    req = v ? (mTrack ? "R3/R4 narrow" : "R2/R4 wide") : "R8 idle";
    check(validOut == v, "R1 validOut", validOut, v);
    check(longint'(ctrlOut) == mOut, req, ctrlOut, mOut);
    check(trackMode == mTrack, "R4 trackMode", trackMode, mTrack);
  endtask

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    doReset();

    // Directed: wide mode, boundary just below threshold (R2)
    step(1, 100, 9949);
    step(1, -250, 0);
    // Idle cycles must hold everything (R8)
    step(0, 12345, 20000);
    step(0, -5, 20000);
    // Exactly at threshold selects narrow mode (R3)
    step(1, 100, 9950);
    step(1, -1, 32767);
    // Negative metric stays wide (R4)
    step(1, 7, -32768);

    // R6: drive the wide integrator into saturation, then read it with e=0
    doReset();
    for (int i = 0; i < 20; i++) step(1, 32767, 0);
    step(1, 0, 0);
    check(ctrlOut == 131071, "R6 wide integ sat", ctrlOut, 131071);
    // R5: narrow integrator kept accumulating while wide was selected
    step(1, 0, 10000);
    check(longint'(ctrlOut) == ((36 * 32767 * 20) >>> 8), "R5 narrow integ",
          ctrlOut, (36 * 32767 * 20) >>> 8);

    // R7: full-scale negative error clips the output
    doReset();
    step(1, -32768, 0);
    check(ctrlOut == -1048576, "R7 out clip", ctrlOut, -1048576);

    // Random mix
    doReset();
    for (int i = 0; i < 3000; i++) begin
      bit     v = ($urandom_range(0, 3) != 0);
      longint e, m;
      if ($urandom_range(0, 1) == 1) e = longint'($urandom_range(0, 400)) - 200;
      else e = longint'($urandom_range(0, 65535)) - 32768;
      case ($urandom_range(0, 2))
        0: m = longint'($urandom_range(0, 100)) + 9900;
        1: m = longint'($urandom_range(0, 65535)) - 32768;
        default: m = THR;
      endcase
      step(v, e, m);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule